// File: doc/BRIEF.md
# Spare Lane Failover Remapper

This block serves one direction of a multi-lane memory-channel link that carries a single spare wire next to its data lanes. It watches the CRC verdict delivered at the end of each transfer. An isolated CRC failure only produces a link-level retry request. A run of consecutive failures that reaches a programmable threshold is treated as a broken wire. When diagnosis names a single data lane, that lane is retired: every data lane from the failed position upward moves one physical lane higher, so the spare lane carries the top data lane. Data width and CRC coverage therefore stay whole after the repair.

The new steering takes effect only while no transfer is on the wire. The retry of the failed transaction is requested in the same cycle that the repaired mapping becomes live. There is only one spare. A second persistent failure, or a persistent failure that cannot be traced to a valid data lane, raises a sticky containment flag and stops all further retries.

The block contains the steering muxes for both directions of data. The outbound path spreads logical lanes across the physical lanes. The inbound path gathers physical lanes back into logical order. Both paths are combinational and have no handshake. The block also publishes the per-physical-lane source index and enable pattern, so that a neighbouring serializer can follow the same mapping.

Top module: `spare_remap_top`

## Requirements
- R1: After reset, failover_o, contain_o and retry_o are 0, failed_lane_o is 0, every data lane p drives physical lane p with lane_sel_o field p equal to p, and the spare (physical lane NLANE) is disabled with lane_en_o bit NLANE equal to 0.
- R2: A strobe (crc_vld_i=1) with crc_err_i=1 that leaves the consecutive-error count below the threshold produces retry_o=1 for exactly the cycle after the strobe and leaves the mapping unchanged.
- R3: A strobe with crc_err_i=0 clears the consecutive-error count. Errors separated by a good CRC never trigger a failover.
- R4: The error strobe whose consecutive count reaches thresh_i (a value of 0 acts as 1) with fault_lane_i=F and F<NLANE retires lane F. failover_o rises, failed_lane_o becomes F, and retry_o pulses in that same cycle, but not on the first cycle after the strobe.
- R5: The remap is applied only on a clock edge where xfer_busy_i is 0. While xfer_busy_i stays 1 the old mapping holds.
- R6: With lane F retired, physical lane p<F carries logical lane p, physical lane F is disabled and drives zero, and physical lane p>F carries logical lane p-1. lane_sel_o field p, of width IDX_W at bit p*IDX_W, holds that source index, or 0 for a disabled lane.
- R7: The inbound path returns logical lane l from physical lane l, or from lane l+1 when a failover is active and l>=F. Sending the outbound output back into the inbound input reproduces the logical data.
- R8: A persistent error while failover is active sets contain_o, gives no retry, and leaves failover_o, failed_lane_o and the mapping unchanged. contain_o then stays 1 until reset.
- R9: A persistent error with fault_lane_i>=NLANE sets contain_o without any remap or retry.
- R10: Once contain_o is 1, no CRC error produces a retry.
- R11: Before failover the outbound data is the identity on lanes 0..NLANE-1 and the spare lane drives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crc_vld_i | input | 1 | CRC verdict strobe, one per transfer |
| crc_err_i | input | 1 | CRC failed for this transfer |
| fault_lane_i | input | IDX_W | Lane index blamed by diagnosis |
| thresh_i | input | THR_W | Consecutive errors judged persistent (0 acts as 1) |
| xfer_busy_i | input | 1 | A transfer is on the wire; remap is held off |
| tx_lanes_i | input | NLANE*LANE_W | Outbound logical lane data |
| phy_tx_o | output | (NLANE+1)*LANE_W | Outbound physical lane data |
| phy_rx_i | input | (NLANE+1)*LANE_W | Inbound physical lane data |
| rx_lanes_o | output | NLANE*LANE_W | Inbound logical lane data |
| lane_en_o | output | NLANE+1 | Physical lane in use |
| lane_sel_o | output | (NLANE+1)*IDX_W | Source logical index per physical lane |
| retry_o | output | 1 | Link-level retry request pulse |
| failover_o | output | 1 | Spare lane in service |
| failed_lane_o | output | IDX_W | Retired lane index (0 when none) |
| contain_o | output | 1 | Uncorrectable link, containment raised |

## Verification
The bench builds the block with eight 4-bit data lanes and a 3-bit threshold. A 4-bit lane index then covers the out-of-range values 8 to 15, and the threshold sweep can include the zero setting. Failover is exercised at the lowest lane, at the highest lane and at a middle lane, so the shift network is seen with nothing shifted, with everything shifted, and with a split. Random runs of good and bad CRCs are held just below the threshold, so that count clearing is tested many times over.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [1:0] {
    ST_NORM   = 2'd0,
    ST_PEND   = 2'd1,
    ST_SPARED = 2'd2,
    ST_DEAD   = 2'd3
  } remap_st_e;
endpackage

// File: rtl/srm_err_track.sv
// Consecutive CRC error counter; classifies each error as transient or persistent.
module srm_err_track #(
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_vld_i,
  input  logic             crc_err_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             trans_o,
  output logic             pers_o
);
  logic [THR_W-1:0] cnt_q;
  logic [THR_W:0]   cnt_inc;
  logic [THR_W:0]   eff_thr;
  logic             err_evt;
  logic             hit;

  assign err_evt = crc_vld_i && crc_err_i;
  assign cnt_inc = {1'b0, cnt_q} + (THR_W+1)'(1);
  assign eff_thr = (thresh_i == '0) ? (THR_W+1)'(1) : {1'b0, thresh_i};
  assign hit     = err_evt && (cnt_inc >= eff_thr);
  assign trans_o = err_evt && !hit;
  assign pers_o  = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (crc_vld_i) begin
      if (!crc_err_i || hit) cnt_q <= '0;
      else                   cnt_q <= cnt_inc[THR_W-1:0];
    end
  end
endmodule

// File: rtl/srm_remap_ctrl.sv
// Failover sequencing: pending remap, apply between transfers, containment.
module srm_remap_ctrl
  import srm_pkg::*;
#(
  parameter int NLANE = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trans_i,
  input  logic             pers_i,
  input  logic [IDX_W-1:0] fault_lane_i,
  input  logic             xfer_busy_i,
  output logic             retry_o,
  output logic             spared_o,
  output logic [IDX_W-1:0] lane_o,
  output logic             contain_o
);
  remap_st_e        st_q;
  logic [IDX_W-1:0] lane_q;
  logic             spared_q;
  logic             contain_q;
  logic             retry_q;
  logic             lane_ok;

  assign lane_ok = fault_lane_i < IDX_W'(NLANE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_NORM;
      lane_q    <= '0;
      spared_q  <= 1'b0;
      contain_q <= 1'b0;
      retry_q   <= 1'b0;
    end else begin
      retry_q <= 1'b0;
      unique case (st_q)
        ST_NORM: begin
          if (trans_i) retry_q <= 1'b1;
          if (pers_i) begin
            if (lane_ok) begin
              st_q   <= ST_PEND;
              lane_q <= fault_lane_i;
            end else begin
              st_q      <= ST_DEAD;
              contain_q <= 1'b1;
            end
          end
        end
        ST_PEND: begin
          if (trans_i) retry_q <= 1'b1;
          if (!xfer_busy_i) begin
            st_q     <= ST_SPARED;
            spared_q <= 1'b1;
            retry_q  <= 1'b1;
          end
        end
        ST_SPARED: begin
          if (trans_i) retry_q <= 1'b1;
          if (pers_i) begin
            st_q      <= ST_DEAD;
            contain_q <= 1'b1;
            retry_q   <= 1'b0;
          end
        end
        default: begin
          st_q <= ST_DEAD;
        end
      endcase
    end
  end

  assign retry_o   = retry_q;
  assign spared_o  = spared_q;
  assign lane_o    = spared_q ? lane_q : '0;
  assign contain_o = contain_q;
endmodule

// File: rtl/srm_lane_steer.sv
// Shift network: outbound spread onto NLANE+1 wires, inbound gather back.
module srm_lane_steer #(
  parameter int NLANE  = 8,
  parameter int LANE_W = 4,
  parameter int IDX_W  = 4,
  localparam int PHY   = NLANE + 1
) (
  input  logic                    spared_i,
  input  logic [IDX_W-1:0]        lane_i,
  input  logic [NLANE*LANE_W-1:0] tx_lanes_i,
  output logic [PHY*LANE_W-1:0]   phy_tx_o,
  input  logic [PHY*LANE_W-1:0]   phy_rx_i,
  output logic [NLANE*LANE_W-1:0] rx_lanes_o,
  output logic [PHY-1:0]          lane_en_o,
  output logic [PHY*IDX_W-1:0]    lane_sel_o
);
  for (genvar p = 0; p < PHY; p++) begin : g_phy
    localparam logic [IDX_W-1:0] PI = IDX_W'(p);
    logic [IDX_W-1:0] src;
    logic             en;
    always_comb begin
      if (!spared_i) begin
        en  = (p < NLANE);
        src = (p < NLANE) ? PI : '0;
      end else if (PI < lane_i) begin
        en  = 1'b1;
        src = PI;
      end else if (PI == lane_i) begin
        en  = 1'b0;
        src = '0;
      end else begin
        en  = 1'b1;
        src = PI - IDX_W'(1);
      end
    end
    assign lane_en_o[p]                   = en;
    assign lane_sel_o[p*IDX_W +: IDX_W]   = src;
    assign phy_tx_o[p*LANE_W +: LANE_W]   =
      en ? LANE_W'(tx_lanes_i >> (src * LANE_W)) : '0;
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_log
    localparam logic [IDX_W-1:0] LI = IDX_W'(l);
    logic up;
    assign up = spared_i && (LI >= lane_i);
    assign rx_lanes_o[l*LANE_W +: LANE_W] =
      up ? phy_rx_i[(l+1)*LANE_W +: LANE_W] : phy_rx_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/spare_remap_top.sv
module spare_remap_top #(
  parameter int NLANE  = 8,
  parameter int LANE_W = 4,
  parameter int THR_W  = 3,
  localparam int PHY   = NLANE + 1,
  localparam int IDX_W = $clog2(PHY)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    crc_vld_i,
  input  logic                    crc_err_i,
  input  logic [IDX_W-1:0]        fault_lane_i,
  input  logic [THR_W-1:0]        thresh_i,
  input  logic                    xfer_busy_i,
  input  logic [NLANE*LANE_W-1:0] tx_lanes_i,
  output logic [PHY*LANE_W-1:0]   phy_tx_o,
  input  logic [PHY*LANE_W-1:0]   phy_rx_i,
  output logic [NLANE*LANE_W-1:0] rx_lanes_o,
  output logic [PHY-1:0]          lane_en_o,
  output logic [PHY*IDX_W-1:0]    lane_sel_o,
  output logic                    retry_o,
  output logic                    failover_o,
  output logic [IDX_W-1:0]        failed_lane_o,
  output logic                    contain_o
);
  logic trans, pers;

  srm_err_track #(.THR_W(THR_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_vld_i (crc_vld_i),
    .crc_err_i (crc_err_i),
    .thresh_i  (thresh_i),
    .trans_o   (trans),
    .pers_o    (pers)
  );

  srm_remap_ctrl #(.NLANE(NLANE), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .trans_i      (trans),
    .pers_i       (pers),
    .fault_lane_i (fault_lane_i),
    .xfer_busy_i  (xfer_busy_i),
    .retry_o      (retry_o),
    .spared_o     (failover_o),
    .lane_o       (failed_lane_o),
    .contain_o    (contain_o)
  );

  srm_lane_steer #(.NLANE(NLANE), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_steer (
    .spared_i   (failover_o),
    .lane_i     (failed_lane_o),
    .tx_lanes_i (tx_lanes_i),
    .phy_tx_o   (phy_tx_o),
    .phy_rx_i   (phy_rx_i),
    .rx_lanes_o (rx_lanes_o),
    .lane_en_o  (lane_en_o),
    .lane_sel_o (lane_sel_o)
  );
endmodule

// File: rtl/spare_remap_chk.sv
module spare_remap_chk #(
  parameter int NLANE = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_busy_i,
  input logic             retry_o,
  input logic             failover_o,
  input logic [IDX_W-1:0] failed_lane_o,
  input logic             contain_o,
  input logic [NLANE:0]   lane_en_o
);
  a_r4_retry_with_remap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failover_o) |-> retry_o);

  a_r4_failover_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    failover_o |=> failover_o && $stable(failed_lane_o));

  a_r5_idle_apply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failover_o) |-> !$past(xfer_busy_i));

  a_r8_contain_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    contain_o |=> contain_o);

  a_r10_no_retry_dead: assert property (@(posedge clk) disable iff (!rst_n)
    contain_o |-> !retry_o);

  a_r6_one_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_en_o) == NLANE);

  a_r9_lane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    failover_o |-> failed_lane_o < IDX_W'(NLANE));
endmodule

bind spare_remap_top spare_remap_chk #(.NLANE(NLANE), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xfer_busy_i   (xfer_busy_i),
  .retry_o       (retry_o),
  .failover_o    (failover_o),
  .failed_lane_o (failed_lane_o),
  .contain_o     (contain_o),
  .lane_en_o     (lane_en_o)
);

// File: tb/spare_remap_top_tb.sv
`timescale 1ns/1ps
module spare_remap_top_tb;
  localparam int NL  = 8;
  localparam int LW  = 4;
  localparam int TW  = 3;
  localparam int PHY = NL + 1;
  localparam int IW  = $clog2(PHY);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crc_vld = 1'b0, crc_err = 1'b0, busy = 1'b0;
  logic [IW-1:0] fault_lane = '0;
  logic [TW-1:0] thr = '0;
  logic [NL*LW-1:0]  tx = '0;
  logic [PHY*LW-1:0] phy_tx, phy_rx = '0;
  logic [NL*LW-1:0]  rx;
  logic [PHY-1:0]    lane_en;
  logic [PHY*IW-1:0] lane_sel;
  logic retry, failover, contain;
  logic [IW-1:0] failed_lane;

  int n_chk = 0, n_bad = 0, m_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spare_remap_top #(.NLANE(NL), .LANE_W(LW), .THR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .crc_vld_i(crc_vld), .crc_err_i(crc_err),
    .fault_lane_i(fault_lane), .thresh_i(thr), .xfer_busy_i(busy),
    .tx_lanes_i(tx), .phy_tx_o(phy_tx), .phy_rx_i(phy_rx), .rx_lanes_o(rx),
    .lane_en_o(lane_en), .lane_sel_o(lane_sel), .retry_o(retry),
    .failover_o(failover), .failed_lane_o(failed_lane), .contain_o(contain)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int src_of(bit sp, int f, int p);
    if (!sp) return (p < NL) ? p : -1;
    if (p < f) return p;
    if (p == f) return -1;
    return p - 1;
  endfunction

  function automatic logic [PHY*LW-1:0] ref_phy(bit sp, int f, logic [NL*LW-1:0] d);
    logic [PHY*LW-1:0] r = '0;
    for (int p = 0; p < PHY; p++) begin
      int s = src_of(sp, f, p);
      if (s >= 0) r[p*LW +: LW] = d[s*LW +: LW];
    end
    return r;
  endfunction

  function automatic logic [PHY*IW-1:0] ref_sel(bit sp, int f);
    logic [PHY*IW-1:0] r = '0;
    for (int p = 0; p < PHY; p++) begin
      int s = src_of(sp, f, p);
      if (s >= 0) r[p*IW +: IW] = IW'(s);
    end
    return r;
  endfunction

  function automatic logic [PHY-1:0] ref_en(bit sp, int f);
    logic [PHY-1:0] r = '0;
    for (int p = 0; p < PHY; p++) r[p] = (src_of(sp, f, p) >= 0);
    return r;
  endfunction

  function automatic logic [NL*LW-1:0] ref_rx(bit sp, int f, logic [PHY*LW-1:0] d);
    logic [NL*LW-1:0] r;
    for (int l = 0; l < NL; l++) begin
      int s = (sp && l >= f) ? l + 1 : l;
      r[l*LW +: LW] = d[s*LW +: LW];
    end
    return r;
  endfunction

  task automatic do_reset();
    crc_vld = 0; crc_err = 0; busy = 0; m_cnt = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic crc(input bit err, input int ln, input bit exp_retry, input string tag);
    @(negedge clk);
    crc_vld = 1; crc_err = err; fault_lane = IW'(ln);
    @(negedge clk);
    crc_vld = 0; crc_err = 0;
    check(tag, retry, exp_retry);
  endtask

  task automatic chk_map(input bit sp, input int f, input string tag);
    check({tag, " en"},  lane_en, ref_en(sp, f));
    check({tag, " sel"}, lane_sel, ref_sel(sp, f));
    for (int i = 0; i < 6; i++) begin
      tx     = {$urandom};
      phy_rx = {$urandom, $urandom};
      #1;
      check({tag, " tx"}, phy_tx, ref_phy(sp, f, tx));
      check({tag, " R7 rx"}, rx, ref_rx(sp, f, phy_rx));
      phy_rx = phy_tx;
      #1;
      check({tag, " R7 loop"}, rx, tx);
    end
  endtask

  // Persistent hit with fault lane f, busy low: remap applied one cycle later.
  task automatic expect_apply(input int f, input string tag);
    @(negedge clk);
    check({tag, " failover"}, failover, 1);
    check({tag, " retry"}, retry, 1);
    check({tag, " lane"}, failed_lane, f);
    @(negedge clk);
    check({tag, " retry end"}, retry, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 reset state
    check("R1 failover", failover, 0);
    check("R1 contain", contain, 0);
    check("R1 retry", retry, 0);
    check("R1 lane", failed_lane, 0);
    chk_map(0, 0, "R11");

    // R2 / R3 transients and count clearing
    thr = 3;
    crc(1, 2, 1, "R2");
    crc(1, 2, 1, "R2");
    check("R2 no remap", failover, 0);
    crc(0, 2, 0, "R3");
    crc(1, 2, 1, "R3");
    crc(1, 2, 1, "R3");
    check("R3 no remap", failover, 0);
    crc(0, 2, 0, "R3");

    // constrained random transients, kept below threshold
    m_cnt = 0;
    thr = TW'(2 + ($urandom % 6));
    for (int i = 0; i < 40; i++) begin
      bit e = bit'($urandom % 2);
      if (e && (m_cnt + 1 >= int'(thr))) e = 0;
      m_cnt = e ? m_cnt + 1 : 0;
      crc(e, $urandom % NL, e, "R3 rand");
    end
    check("R3 rand no remap", failover, 0);
    chk_map(0, 0, "R11 rand");
    crc(0, 0, 0, "R3");

    // R4 / R5 persistent error held off by busy
    thr = 3; busy = 1;
    crc(1, 5, 1, "R4");
    crc(1, 5, 1, "R4");
    crc(1, 5, 0, "R4 hit");
    repeat (4) @(negedge clk);
    check("R5 held", failover, 0);
    check("R5 no retry", retry, 0);
    busy = 0;
    expect_apply(5, "R5");
    chk_map(1, 5, "R6 mid");

    // transient still retried after failover
    crc(1, 3, 1, "R2 spared");
    crc(0, 3, 0, "R3");
    // R8 second persistent
    crc(1, 3, 1, "R8");
    crc(1, 3, 1, "R8");
    crc(1, 3, 0, "R8 hit");
    @(negedge clk);
    check("R8 contain", contain, 1);
    check("R8 failover", failover, 1);
    check("R8 lane", failed_lane, 5);
    chk_map(1, 5, "R8");
    crc(1, 1, 0, "R10");
    crc(1, 1, 0, "R10");
    check("R8 sticky", contain, 1);

    // R4 threshold zero acts as one, lowest lane
    do_reset();
    thr = 0;
    crc(1, 0, 0, "R4 thr0");
    expect_apply(0, "R4 thr0");
    chk_map(1, 0, "R6 low");

    // highest lane
    do_reset();
    thr = 1;
    crc(1, NL-1, 0, "R4 top");
    expect_apply(NL-1, "R4 top");
    chk_map(1, NL-1, "R6 top");

    // R9 untraceable lane
    do_reset();
    thr = 2;
    crc(1, NL, 1, "R9");
    crc(1, NL, 0, "R9 hit");
    repeat (2) @(negedge clk);
    check("R9 contain", contain, 1);
    check("R9 failover", failover, 0);
    check("R9 retry", retry, 0);
    chk_map(0, 0, "R9");
    crc(1, 2, 0, "R10 after R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule